// File: doc/BRIEF.md
# Normalizing Shift-Subtract Divider

This block divides one unsigned integer by another over several clock cycles and returns the integer quotient. The remainder is not returned. A request carries a numerator and a denominator and is accepted through a valid/ready handshake. The result, a quotient and an error flag, leaves through a second valid/ready handshake.

Inside, the denominator is first aligned. It shifts left one bit per cycle until its most significant bit is set. A one-hot weight, loaded as 1, shifts left with it. The quotient is then built one bit per cycle: whenever the shifted denominator fits into the running remainder, it is subtracted and the weight is added to the quotient. After each of these steps both the denominator and the weight shift right by one bit.

The run ends with the step that moves the weight to zero. As a result, small denominators take longer than large ones. A zero denominator would never align, so it is recognised when the request is accepted and is answered at once with the error flag set.

Back-pressure rules:
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high only while the block is idle.
- A result is handed over on an edge where `res_valid` and `res_ready` are both high.
- While `res_valid` is high and `res_ready` is low, the result waits unchanged.

Top module: `nsd_divider`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` is 0, `res_err` is 0 and `res_quot` is 0.
- R2: For a nonzero denominator with z leading zero bits within the W-bit word, `res_valid` is first high right after the (2z+2)-th rising edge that follows the accepting edge.
- R3: For a nonzero denominator, `res_quot` equals the numerator divided by the denominator, rounded down, for every pair of W-bit unsigned operands.
- R4: Edge cases return exact results: a numerator below the denominator gives 0, a denominator of 1 gives the numerator, equal operands give 1, and the all-ones numerator over the all-ones denominator gives 1.
- R5: A zero denominator raises `res_valid` together with `res_err` = 1 right after the accepting edge, with `res_quot` = 0.
- R6: `res_err` is 0 for every result with a nonzero denominator.
- R7: From the accepting edge until the result is handed over, `req_ready` is 0, and a request offered in that time has no effect on the pending result.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_quot` and `res_err` all hold their values.
- R9: After the result is handed over, `res_quot` keeps its value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_num | input | W | Numerator, unsigned |
| req_den | input | W | Denominator, unsigned |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_quot | output | W | Quotient, rounded down |
| res_err | output | 1 | Result came from a zero denominator |

## Verification
The bench builds the block with its default width W = 31.

A denominator of 1 therefore needs thirty alignment shifts followed by thirty-one reduction steps. This is the longest run the block can have, and it meets the all-ones numerator at the top of the operand range. Denominators with the top bit already set exercise the shortest path, where no alignment shift is needed at all.

Random denominators are drawn with random magnitudes so that every alignment depth gets used. Random stalls on `res_ready` keep the hold and idle behaviour under pressure throughout the run.

// File: rtl/nsd_pkg.sv
package nsd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ALIGN  = 2'd1,
    ST_REDUCE = 2'd2,
    ST_HOLD   = 2'd3
  } nsd_state_e;
endpackage

// File: rtl/nsd_ctrl.sv
module nsd_ctrl
  import nsd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic den_zero,
  input  logic dsr_top,
  input  logic wgt_last,
  input  logic res_ready,
  output logic req_ready,
  output logic res_valid,
  output logic res_err,
  output logic load,
  output logic shl,
  output logic step
);
  nsd_state_e state;

  assign req_ready = (state == ST_IDLE);
  assign res_valid = (state == ST_HOLD);
  assign load      = req_valid && req_ready;
  assign shl       = (state == ST_ALIGN) && !dsr_top;
  assign step      = (state == ST_REDUCE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      res_err <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (load) begin
          state   <= den_zero ? ST_HOLD : ST_ALIGN;
          res_err <= den_zero;
        end
        ST_ALIGN:  if (dsr_top)   state <= ST_REDUCE;
        ST_REDUCE: if (wgt_last)  state <= ST_HOLD;
        ST_HOLD:   if (res_ready) state <= ST_IDLE;
        default:                  state <= ST_IDLE;
      endcase
    end
  end

  // R5: zero denominator answered right after the accepting edge
  p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && den_zero) |=> (res_valid && res_err));

  // R2: reduction only begins on an aligned divisor
  p_reduce_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step) |-> dsr_top);

  // R7: no new request is taken while a result is pending
  p_no_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> !req_ready);
endmodule

// File: rtl/nsd_align.sv
module nsd_align #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shl,
  input  logic         step,
  input  logic [W-1:0] den,
  output logic [W-1:0] dsr,
  output logic [W-1:0] wgt,
  output logic         den_zero,
  output logic         dsr_top,
  output logic         wgt_last
);
  localparam logic [W-1:0] UNIT = W'(1);

  assign den_zero = (den == '0);
  assign dsr_top  = dsr[W-1];
  assign wgt_last = wgt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsr <= '0;
      wgt <= '0;
    end else if (load) begin
      dsr <= den;
      wgt <= UNIT;
    end else if (shl) begin
      dsr <= dsr << 1;
      wgt <= wgt << 1;
    end else if (step) begin
      dsr <= dsr >> 1;
      wgt <= wgt >> 1;
    end
  end

  // R2: the weight stays a single set bit (or empty) through every shift
  p_weight_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wgt));
endmodule

// File: rtl/nsd_accum.sv
module nsd_accum #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] num,
  input  logic [W-1:0] dsr,
  input  logic [W-1:0] wgt,
  output logic [W-1:0] quot
);
  logic [W-1:0] rem;
  logic [W-1:0] diff;
  logic         borrow;

  always_comb begin
    {borrow, diff} = {1'b0, rem} - {1'b0, dsr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      quot <= '0;
    end else if (load) begin
      rem  <= num;
      quot <= '0;
    end else if (step && !borrow) begin
      rem  <= diff;
      quot <= quot + wgt;
    end
  end

  // R3: the remainder never reaches twice the current divisor
  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ({1'b0, rem} < {dsr, 1'b0}));
endmodule

// File: rtl/nsd_divider.sv
module nsd_divider #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_num,
  input  logic [W-1:0] req_den,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_quot,
  output logic         res_err
);
  logic         load, shl, step;
  logic         den_zero, dsr_top, wgt_last;
  logic [W-1:0] dsr, wgt;

  nsd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .den_zero  (den_zero),
    .dsr_top   (dsr_top),
    .wgt_last  (wgt_last),
    .res_ready (res_ready),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .res_err   (res_err),
    .load      (load),
    .shl       (shl),
    .step      (step)
  );

  nsd_align #(.W(W)) u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .shl      (shl),
    .step     (step),
    .den      (req_den),
    .dsr      (dsr),
    .wgt      (wgt),
    .den_zero (den_zero),
    .dsr_top  (dsr_top),
    .wgt_last (wgt_last)
  );

  nsd_accum #(.W(W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .num   (req_num),
    .dsr   (dsr),
    .wgt   (wgt),
    .quot  (res_quot)
  );

  // R8: a stalled result holds
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_quot) && $stable(res_err)));

  // R9: idle without a request leaves the quotient untouched
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> $stable(res_quot));
endmodule

// File: tb/nsd_divider_test.sv
`timescale 1ns/1ps
module nsd_divider_test;
  localparam int W = 31;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n, req_valid, req_ready, res_valid, res_ready, res_err;
  logic [W-1:0] req_num, req_den, res_quot;

  nsd_divider #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_num(req_num), .req_den(req_den), .res_valid(res_valid),
    .res_ready(res_ready), .res_quot(res_quot), .res_err(res_err)
  );

  typedef struct packed {
    logic [W-1:0] q;
    logic         e;
    logic         edge_c;
    int           acc;
    int           lat;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   done_flag = 0;

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic int lat_of(input logic [W-1:0] d);
    int z = 0;
    if (d == '0) return 0;
    while (!d[W-1]) begin d = d << 1; z++; end
    return 2 * z + 2;
  endfunction

  task automatic send(input logic [W-1:0] num, input logic [W-1:0] den,
                      input bit edge_c, input bit junk);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_num = num; req_den = den;
    while (!req_ready) @(negedge clk);
    e.q = (den == '0) ? '0 : num / den;
    e.e = (den == '0);
    e.edge_c = edge_c;
    e.acc = cyc + 1;
    e.lat = lat_of(den);
    sb.push_back(e);
    @(negedge clk);
    if (junk) begin
      req_num = ~num; req_den = W'(1);
      chk(req_ready == 1'b0, "R7", "ready while busy", req_ready, 0);
      @(negedge clk);
      chk(req_ready == 1'b0, "R7", "ready while busy", req_ready, 0);
    end
    req_valid = 1'b0;
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor / scoreboard
  initial begin
    bit           seen = 0, have_last = 0;
    logic [W-1:0] hq = '0, last_q = '0;
    logic         he = 1'b0;
    int           stall = 0;
    exp_t         cur;
    res_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (res_valid) begin
          if (!seen) begin
            if (sb.size() == 0) begin
              chk(0, "R7", "unexpected result", 1, 0);
            end else begin
              cur = sb[0];
              chk(cyc - cur.acc == cur.lat, cur.e ? "R5" : "R2", "latency",
                  cyc - cur.acc, cur.lat);
              chk(res_quot == cur.q, cur.e ? "R5" : (cur.edge_c ? "R4" : "R3"),
                  "quotient", res_quot, cur.q);
              chk(res_err == cur.e, cur.e ? "R5" : "R6", "error flag", res_err, cur.e);
            end
            seen = 1; hq = res_quot; he = res_err;
            stall = int'($urandom % 4);
          end else begin
            chk(res_quot == hq, "R8", "held quotient", res_quot, hq);
            chk(res_err == he, "R8", "held error", res_err, he);
          end
          if (stall == 0) begin
            res_ready = 1'b1;
            if (sb.size() != 0) void'(sb.pop_front());
            seen = 0; have_last = 1; last_q = hq;
          end else begin
            res_ready = 1'b0;
            stall--;
          end
        end else begin
          res_ready = 1'b0;
          if (have_last && req_ready)
            chk(res_quot == last_q, "R9", "idle quotient", res_quot, last_q);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_num = '0; req_den = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(res_valid == 1'b0, "R1", "res_valid", res_valid, 0);
    chk(res_err == 1'b0, "R1", "res_err", res_err, 0);
    chk(res_quot == '0, "R1", "res_quot", res_quot, 0);

    // R4 edge cases
    send(W'(100), W'(1), 1, 0);
    send(ONES, W'(1), 1, 0);
    send(W'(5), W'(7), 1, 0);
    send(W'(7), W'(7), 1, 0);
    send(ONES, ONES, 1, 0);
    send(W'(0), W'(5), 1, 0);
    send(W'(1) << (W-1), W'(3), 0, 0);
    send(ONES, W'(1) << (W-1), 0, 0);
    // R5 zero denominator
    send(W'(123), W'(0), 0, 0);
    send(W'(0), W'(0), 0, 0);
    // R7 request offered while busy
    send(W'(1000), W'(3), 0, 1);
    send(ONES, W'(1) << (W-1), 0, 1);
    // R3 random operands of random magnitude
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] n, d;
      n = W'($urandom) >> ($urandom % W);
      d = W'($urandom) >> ($urandom % W);
      if (i % 37 == 0) d = '0;
      send(n, d, 0, (i % 11 == 0) && (d != '0));
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule